// File: doc/BRIEF.md
# Storage Key Access Checker

This block sits beside the load/store path and decides, in the same cycle a request is presented, whether a memory access may go ahead. The request's virtual page is looked up in a small fully associative translation buffer. Each entry carries a virtual page number, a physical page number, two page permission bits and a storage key number. The key taken from the matching entry selects a read/write deny pair in a per-context authority mask. An access completes only when both the page permission bits and the key's deny bit allow it. Otherwise a data storage interrupt is raised.

On a protection fault the block records the faulting virtual address, whether the access was a store, and which layer refused it. It keeps that record until software clears it. A lookup that finds no entry is reported on a separate miss line and never counts as a protection fault.

The translation buffer is loaded one entry per cycle in round-robin order. A single input empties the whole buffer. The authority mask can be replaced in one cycle without touching the buffer, so a context switch costs no translation refill.

Top module: `skey_checker`

## Requirements
- R1: For a load that hits, mask bit 2k+1 (k = the entry's key, 32 keys, 64-bit mask) denies the read when set. A denied read raises `dsi` with the key cause (`faultKeyCause` = 1). The write bit 2k has no effect on loads.
- R2: For a store that hits, mask bit 2k denies the write when set and raises `dsi` with the key cause. The read bit 2k+1 has no effect on stores.
- R3: Page permission bit 0 allows reads and bit 1 allows writes. An access whose page bit is clear raises `dsi` with the page cause (`faultKeyCause` = 0), even when the key allows it.
- R4: When both the page permission and the key refuse an access, the recorded cause is the page cause.
- R5: A valid request that matches no valid entry asserts `tlbMiss`. It asserts neither `dsi` nor `accessOk`, and it records no fault.
- R6: On the clock edge after a `dsi` with no fault held, the block records `faultValid` = 1 along with the request's address, its store flag and its cause. While `faultValid` is set, later faults leave the record unchanged. `statusClr` empties the record, and a fault in that same cycle is recorded instead.
- R7: A write to the authority mask takes effect on the access in the following cycle. An access in the same cycle uses the old mask. A mask write invalidates no translation entry.
- R8: Fills go to entries 0, 1, ..., N-1 in turn and then wrap, so the (N+1)-th fill replaces the first entry loaded.
- R9: `invAll` clears every valid bit in one cycle and returns the fill pointer to entry 0. A fill in the same cycle is dropped.
- R10: An allowed access asserts `accessOk`. `physAddr` then equals the entry's physical page number joined with the request's page offset.
- R11: With `reqValid` low, `accessOk`, `dsi` and `tlbMiss` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqVaddr | input | VA_W | Virtual address of the access |
| accessOk | output | 1 | Access allowed |
| dsi | output | 1 | Data storage interrupt (protection fault) |
| tlbMiss | output | 1 | No translation entry matched |
| physAddr | output | PA_W | Translated address |
| amrWe | input | 1 | Write the authority mask |
| amrWdata | input | 2*NUM_KEYS | New mask value, pair k at bits 2k+1 (read deny) and 2k (write deny) |
| fillValid | input | 1 | Load one translation entry |
| fillVpn | input | VA_W-PAGE_BITS | Virtual page number for the fill |
| fillPpn | input | PA_W-PAGE_BITS | Physical page number for the fill |
| fillPerm | input | 2 | Page permissions: bit 0 read allowed, bit 1 write allowed |
| fillKey | input | log2(NUM_KEYS) | Storage key of the page |
| invAll | input | 1 | Invalidate every entry |
| statusClr | input | 1 | Clear the fault record |
| faultValid | output | 1 | A fault is recorded |
| faultVaddr | output | VA_W | Recorded faulting address |
| faultStore | output | 1 | Recorded fault was a store |
| faultKeyCause | output | 1 | 1 = key refused, 0 = page permission refused |

## Verification
The assertions assume that no two valid entries share a virtual page number. With duplicates, the lowest-numbered match would win silently, and the uniqueness of an outcome would rest on that. The stimulus keeps within this assumption: it only fills pages not already resident, or pages whose earlier copy has been evicted or flushed. The properties also assume the inputs are stable across a cycle, because the response is combinational. The bench therefore changes inputs just after an edge and samples mid-cycle, so every recorded fault reflects exactly one request.

// File: rtl/skey_pkg.sv
package skey_pkg;

  // page permission bit positions within an entry
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic fillEn;
    logic invEn;
    logic amrEn;
    logic capEn;
    logic clrEn;
    logic causeKey;
  } ctrlStrobes_t;

  // lookup outcome from datapath to control
  typedef struct packed {
    logic hit;
    logic pageOk;
    logic keyOk;
  } lookupRes_t;

endpackage

// File: rtl/skey_dp.sv
module skey_dp
  import skey_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8,
  parameter int NUM_KEYS  = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strb,
  input  logic                        reqStore,
  input  logic [VA_W-1:0]             reqVaddr,
  input  logic [2*NUM_KEYS-1:0]       amrWdata,
  input  logic [VA_W-PAGE_BITS-1:0]   fillVpn,
  input  logic [PA_W-PAGE_BITS-1:0]   fillPpn,
  input  logic [1:0]                  fillPerm,
  input  logic [$clog2(NUM_KEYS)-1:0] fillKey,
  output lookupRes_t                  look,
  output logic [PA_W-1:0]             physAddr,
  output logic                        faultValid,
  output logic [VA_W-1:0]             faultVaddr,
  output logic                        faultStore,
  output logic                        faultKeyCause
);

  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int PPN_W  = PA_W - PAGE_BITS;
  localparam int KEY_W  = $clog2(NUM_KEYS);
  localparam int MASK_W = 2 * NUM_KEYS;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // translation buffer storage
  logic [ENTRIES-1:0] entValid;
  logic [VPN_W-1:0]   entVpn  [ENTRIES];
  logic [PPN_W-1:0]   entPpn  [ENTRIES];
  logic [1:0]         entPerm [ENTRIES];
  logic [KEY_W-1:0]   entKey  [ENTRIES];
  logic [IDX_W-1:0]   rrPtr;

  logic [MASK_W-1:0]  authMask;

  logic [VPN_W-1:0]   reqVpn;
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   selIdx;
  logic [PPN_W-1:0]   selPpn;
  logic [1:0]         selPerm;
  logic [KEY_W-1:0]   selKey;
  logic               rdDeny;
  logic               wrDeny;

  assign reqVpn = reqVaddr[VA_W-1:PAGE_BITS];

  // one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = entValid[g] && (entVpn[g] == reqVpn);
  end

  // lowest matching index wins
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign selPpn  = entPpn[selIdx];
  assign selPerm = entPerm[selIdx];
  assign selKey  = entKey[selIdx];

  // key k: odd bit denies reads, even bit denies writes
  assign rdDeny = authMask[{selKey, 1'b1}];
  assign wrDeny = authMask[{selKey, 1'b0}];

  always_comb begin
    look.hit    = |matchVec;
    look.pageOk = reqStore ? selPerm[PERM_WR] : selPerm[PERM_RD];
    look.keyOk  = reqStore ? !wrDeny : !rdDeny;
  end

  assign physAddr = {selPpn, reqVaddr[PAGE_BITS-1:0]};

  // valid bits and replacement pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      rrPtr    <= '0;
    end else if (strb.invEn) begin
      entValid <= '0;
      rrPtr    <= '0;
    end else if (strb.fillEn) begin
      entValid[rrPtr] <= 1'b1;
      rrPtr           <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  // entry payload, no reset needed behind valid bits
  always_ff @(posedge clk) begin
    if (strb.fillEn) begin
      entVpn[rrPtr]  <= fillVpn;
      entPpn[rrPtr]  <= fillPpn;
      entPerm[rrPtr] <= fillPerm;
      entKey[rrPtr]  <= fillKey;
    end
  end

  // per-context authority mask
  always_ff @(posedge clk) begin
    if (!rstN) authMask <= '0;
    else if (strb.amrEn) authMask <= amrWdata;
  end

  // fault record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultValid    <= 1'b0;
      faultVaddr    <= '0;
      faultStore    <= 1'b0;
      faultKeyCause <= 1'b0;
    end else if (strb.capEn) begin
      faultValid    <= 1'b1;
      faultVaddr    <= reqVaddr;
      faultStore    <= reqStore;
      faultKeyCause <= strb.causeKey;
    end else if (strb.clrEn) begin
      faultValid    <= 1'b0;
    end
  end

endmodule

// File: rtl/skey_ctrl.sv
module skey_ctrl
  import skey_pkg::*;
(
  input  logic         reqValid,
  input  logic         amrWe,
  input  logic         fillValid,
  input  logic         invAll,
  input  logic         statusClr,
  input  logic         faultValid,
  input  lookupRes_t   look,
  output ctrlStrobes_t strb,
  output logic         accessOk,
  output logic         dsi,
  output logic         tlbMiss
);

  logic allowed;

  assign allowed  = look.pageOk && look.keyOk;
  assign accessOk = reqValid && look.hit && allowed;
  assign dsi      = reqValid && look.hit && !allowed;
  assign tlbMiss  = reqValid && !look.hit;

  always_comb begin
    strb.invEn    = invAll;
    strb.fillEn   = fillValid && !invAll;
    strb.amrEn    = amrWe;
    strb.clrEn    = statusClr;
    strb.capEn    = dsi && (!faultValid || statusClr);
    // page refusal outranks key refusal
    strb.causeKey = look.pageOk;
  end

endmodule

// File: rtl/skey_checker.sv
module skey_checker
  import skey_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8,
  parameter int NUM_KEYS  = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        reqStore,
  input  logic [VA_W-1:0]             reqVaddr,
  output logic                        accessOk,
  output logic                        dsi,
  output logic                        tlbMiss,
  output logic [PA_W-1:0]             physAddr,
  input  logic                        amrWe,
  input  logic [2*NUM_KEYS-1:0]       amrWdata,
  input  logic                        fillValid,
  input  logic [VA_W-PAGE_BITS-1:0]   fillVpn,
  input  logic [PA_W-PAGE_BITS-1:0]   fillPpn,
  input  logic [1:0]                  fillPerm,
  input  logic [$clog2(NUM_KEYS)-1:0] fillKey,
  input  logic                        invAll,
  input  logic                        statusClr,
  output logic                        faultValid,
  output logic [VA_W-1:0]             faultVaddr,
  output logic                        faultStore,
  output logic                        faultKeyCause
);

  ctrlStrobes_t strb;
  lookupRes_t   look;

  skey_ctrl u_ctrl (
    .reqValid  (reqValid),
    .amrWe     (amrWe),
    .fillValid (fillValid),
    .invAll    (invAll),
    .statusClr (statusClr),
    .faultValid(faultValid),
    .look      (look),
    .strb      (strb),
    .accessOk  (accessOk),
    .dsi       (dsi),
    .tlbMiss   (tlbMiss)
  );

  skey_dp #(
    .VA_W     (VA_W),
    .PA_W     (PA_W),
    .PAGE_BITS(PAGE_BITS),
    .ENTRIES  (ENTRIES),
    .NUM_KEYS (NUM_KEYS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqStore     (reqStore),
    .reqVaddr     (reqVaddr),
    .amrWdata     (amrWdata),
    .fillVpn      (fillVpn),
    .fillPpn      (fillPpn),
    .fillPerm     (fillPerm),
    .fillKey      (fillKey),
    .look         (look),
    .physAddr     (physAddr),
    .faultValid   (faultValid),
    .faultVaddr   (faultVaddr),
    .faultStore   (faultStore),
    .faultKeyCause(faultKeyCause)
  );

endmodule

// File: rtl/skey_chk.sv
module skey_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqStore,
  input logic [VA_W-1:0] reqVaddr,
  input logic            accessOk,
  input logic            dsi,
  input logic            tlbMiss,
  input logic            invAll,
  input logic            statusClr,
  input logic            faultValid,
  input logic [VA_W-1:0] faultVaddr,
  input logic            faultStore,
  input logic            faultKeyCause
);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(accessOk || dsi || tlbMiss));

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ($countones({accessOk, dsi, tlbMiss}) == 1));

  // R5
  miss_no_record_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!faultValid && !dsi) |=> !faultValid);

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dsi && (!faultValid || statusClr)) |=>
      (faultValid && faultVaddr == $past(reqVaddr) && faultStore == $past(reqStore)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !statusClr) |=>
      (faultValid && $stable(faultVaddr) && $stable(faultStore) && $stable(faultKeyCause)));

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    invAll |=> (!reqValid || tlbMiss));

endmodule

bind skey_checker skey_chk #(.VA_W(VA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqStore     (reqStore),
  .reqVaddr     (reqVaddr),
  .accessOk     (accessOk),
  .dsi          (dsi),
  .tlbMiss      (tlbMiss),
  .invAll       (invAll),
  .statusClr    (statusClr),
  .faultValid   (faultValid),
  .faultVaddr   (faultVaddr),
  .faultStore   (faultStore),
  .faultKeyCause(faultKeyCause)
);

// File: tb/sim_skey_checker.sv
module sim_skey_checker;

  localparam int VA_W = 32, PA_W = 32, PAGE_BITS = 12, ENTRIES = 8, NUM_KEYS = 32;
  localparam int VPN_W = VA_W - PAGE_BITS, PPN_W = PA_W - PAGE_BITS;
  localparam int KEY_W = $clog2(NUM_KEYS), MASK_W = 2 * NUM_KEYS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 0, reqStore = 0;
  logic [VA_W-1:0] reqVaddr = '0;
  logic accessOk, dsi, tlbMiss;
  logic [PA_W-1:0] physAddr;
  logic amrWe = 0;
  logic [MASK_W-1:0] amrWdata = '0;
  logic fillValid = 0;
  logic [VPN_W-1:0] fillVpn = '0;
  logic [PPN_W-1:0] fillPpn = '0;
  logic [1:0] fillPerm = '0;
  logic [KEY_W-1:0] fillKey = '0;
  logic invAll = 0, statusClr = 0;
  logic faultValid, faultStore, faultKeyCause;
  logic [VA_W-1:0] faultVaddr;

  skey_checker u0 (.*);

  int checks = 0;
  int errors = 0;

  task automatic chkEq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // bench-side page layout
  function automatic logic [VPN_W-1:0] vpnOf(int i);
    return VPN_W'(32'h100 + i);
  endfunction
  function automatic logic [PPN_W-1:0] ppnOf(int i);
    return PPN_W'(32'h800 + i);
  endfunction
  function automatic logic [KEY_W-1:0] keyOf(int i);
    if (i == 4) return KEY_W'(0);
    if (i == 7) return KEY_W'(31);
    return KEY_W'(4 * i + 1);
  endfunction
  // perm: bit0 read allowed, bit1 write allowed
  function automatic logic [1:0] permOf(int i);
    case (i)
      1: return 2'b01;
      2: return 2'b10;
      3: return 2'b00;
      default: return 2'b11;
    endcase
  endfunction

  task automatic doFill(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, logic [1:0] pm, logic [KEY_W-1:0] k);
    fillValid = 1; fillVpn = v; fillPpn = p; fillPerm = pm; fillKey = k;
    tick();
    fillValid = 0;
  endtask

  task automatic setMask(logic [MASK_W-1:0] m);
    amrWe = 1; amrWdata = m;
    tick();
    amrWe = 0;
  endtask

  task automatic clearStatus();
    statusClr = 1;
    tick();
    statusClr = 0;
  endtask

  // drive a request and wait to mid-cycle
  task automatic drive(logic [VPN_W-1:0] v, logic st, logic [PAGE_BITS-1:0] ofs);
    reqValid = 1; reqStore = st; reqVaddr = {v, ofs};
    #2;
  endtask

  // outcome code: 0 ok, 1 page fault, 2 key fault, 3 miss
  task automatic checkOutcome(string req, int exp);
    chkEq(req, "accessOk", 64'(accessOk), 64'(exp == 0));
    chkEq(req, "dsi", 64'(dsi), 64'(exp == 1 || exp == 2));
    chkEq(req, "tlbMiss", 64'(tlbMiss), 64'(exp == 3));
  endtask

  // table: {key[4:0], deny{rd,wr}[1:0], entry[3:0] (8 = unmapped), store, exp[1:0]}
  localparam int NVEC = 17;
  localparam logic [13:0] VEC [NVEC] = '{
    {5'd1,  2'b00, 4'd0, 1'b0, 2'd0},
    {5'd1,  2'b10, 4'd0, 1'b0, 2'd2},
    {5'd1,  2'b10, 4'd0, 1'b1, 2'd0},
    {5'd1,  2'b01, 4'd0, 1'b1, 2'd2},
    {5'd1,  2'b01, 4'd0, 1'b0, 2'd0},
    {5'd5,  2'b00, 4'd1, 1'b1, 2'd1},
    {5'd5,  2'b00, 4'd1, 1'b0, 2'd0},
    {5'd9,  2'b00, 4'd2, 1'b0, 2'd1},
    {5'd9,  2'b01, 4'd2, 1'b1, 2'd2},
    {5'd13, 2'b11, 4'd3, 1'b1, 2'd1},
    {5'd13, 2'b11, 4'd3, 1'b0, 2'd1},
    {5'd0,  2'b10, 4'd4, 1'b0, 2'd2},
    {5'd31, 2'b10, 4'd7, 1'b0, 2'd2},
    {5'd31, 2'b01, 4'd7, 1'b1, 2'd2},
    {5'd30, 2'b11, 4'd7, 1'b0, 2'd0},
    {5'd0,  2'b11, 4'd5, 1'b0, 2'd0},
    {5'd1,  2'b00, 4'd8, 1'b0, 2'd3}
  };

  bit finished = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();

    // reset state (R11, R6)
    chkEq("R11", "reset accessOk", 64'(accessOk), 0);
    chkEq("R11", "reset dsi", 64'(dsi), 0);
    chkEq("R11", "reset tlbMiss", 64'(tlbMiss), 0);
    chkEq("R6", "reset faultValid", 64'(faultValid), 0);
    // R5: empty buffer after reset misses
    drive(vpnOf(0), 0, 12'h010);
    checkOutcome("R5", 3);
    tick();
    reqValid = 0;
    chkEq("R5", "no record on miss", 64'(faultValid), 0);

    for (int i = 0; i < ENTRIES; i++) doFill(vpnOf(i), ppnOf(i), permOf(i), keyOf(i));

    // table walk (R1 R2 R3 R4 R5 R6 R10)
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] k;
      logic [1:0] dn;
      logic [3:0] ent;
      logic st;
      int ex;
      logic [VPN_W-1:0] vp;
      logic [PAGE_BITS-1:0] ofs;
      string rq;
      k = VEC[v][13:9]; dn = VEC[v][8:7]; ent = VEC[v][6:3]; st = VEC[v][2]; ex = int'(VEC[v][1:0]);
      rq = (ex == 3) ? "R5" : (ex == 0) ? "R10" : (ex == 1) ? (dn != 0 ? "R4" : "R3") : (st ? "R2" : "R1");
      setMask(MASK_W'(dn) << (2 * k));
      vp = (ent == 8) ? VPN_W'(32'h1FF) : vpnOf(int'(ent));
      ofs = PAGE_BITS'(12'h5A0 + v);
      drive(vp, st, ofs);
      checkOutcome(rq, ex);
      if (ex == 0) chkEq("R10", "physAddr", 64'(physAddr), 64'({ppnOf(int'(ent)), ofs}));
      tick();
      reqValid = 0;
      chkEq(rq, "faultValid", 64'(faultValid), 64'(ex == 1 || ex == 2));
      if (ex == 1 || ex == 2) begin
        chkEq("R6", "faultVaddr", 64'(faultVaddr), 64'({vp, ofs}));
        chkEq("R6", "faultStore", 64'(faultStore), 64'(st));
        chkEq(rq, "faultKeyCause", 64'(faultKeyCause), 64'(ex == 2));
        clearStatus();
        chkEq("R6", "cleared", 64'(faultValid), 0);
      end
    end

    // R11: idle with everything denied
    setMask('1);
    #2;
    chkEq("R11", "idle outputs", 64'({accessOk, dsi, tlbMiss}), 0);

    // R7: same-cycle write uses old mask, next cycle new mask, entries survive
    setMask('0);
    amrWe = 1; amrWdata = MASK_W'(2'b10) << 2;  // key 1 read deny
    drive(vpnOf(0), 0, 12'h111);
    checkOutcome("R7", 0);
    tick();
    amrWe = 0;
    #2;
    checkOutcome("R7", 2);
    tick();
    reqValid = 0;
    clearStatus();
    setMask('0);
    drive(vpnOf(6), 0, 12'h222);
    checkOutcome("R7", 0);
    tick();
    reqValid = 0;

    // R6: first fault held against a later one
    drive(vpnOf(3), 0, 12'h333);      // page fault on load
    tick();
    setMask(MASK_W'(2'b01) << 2);     // key 1 write deny
    drive(vpnOf(0), 1, 12'h444);      // key fault on store
    checkOutcome("R6", 2);
    tick();
    reqValid = 0;
    chkEq("R6", "held vaddr", 64'(faultVaddr), 64'({vpnOf(3), 12'h333}));
    chkEq("R6", "held store", 64'(faultStore), 0);
    chkEq("R6", "held cause", 64'(faultKeyCause), 0);
    // clear with a fault in the same cycle records the new one
    statusClr = 1;
    drive(vpnOf(0), 1, 12'h555);
    tick();
    statusClr = 0; reqValid = 0;
    chkEq("R6", "clr+fault valid", 64'(faultValid), 1);
    chkEq("R6", "clr+fault vaddr", 64'(faultVaddr), 64'({vpnOf(0), 12'h555}));
    chkEq("R6", "clr+fault cause", 64'(faultKeyCause), 1);
    clearStatus();
    chkEq("R6", "clear", 64'(faultValid), 0);
    setMask('0);

    // R8: ninth fill evicts entry loaded first
    doFill(VPN_W'(32'h200), PPN_W'(32'h900), 2'b11, KEY_W'(2));
    drive(vpnOf(0), 0, 12'h0);
    checkOutcome("R8", 3);
    tick();
    drive(VPN_W'(32'h200), 0, 12'h0AB);
    checkOutcome("R8", 0);
    chkEq("R8", "physAddr", 64'(physAddr), 64'({PPN_W'(32'h900), 12'h0AB}));
    tick();
    drive(vpnOf(1), 0, 12'h0);
    checkOutcome("R8", 0);
    tick();
    reqValid = 0;

    // R9: flush, fill dropped in same cycle, pointer back to 0
    invAll = 1;
    tick();
    invAll = 0;
    drive(vpnOf(1), 0, 12'h0);
    checkOutcome("R9", 3);
    tick();
    reqValid = 0;
    invAll = 1; fillValid = 1; fillVpn = VPN_W'(32'h300); fillPpn = '0; fillPerm = 2'b11; fillKey = '0;
    tick();
    invAll = 0; fillValid = 0;
    drive(VPN_W'(32'h300), 0, 12'h0);
    checkOutcome("R9", 3);
    tick();
    reqValid = 0;
    for (int i = 0; i < ENTRIES + 1; i++)
      doFill(VPN_W'(32'h400 + i), PPN_W'(32'hA00 + i), 2'b11, KEY_W'(0));
    drive(VPN_W'(32'h400), 0, 12'h0);
    checkOutcome("R9", 3);
    tick();
    drive(VPN_W'(32'h408), 0, 12'h0);
    checkOutcome("R9", 0);
    tick();
    drive(VPN_W'(32'h401), 0, 12'h0);
    checkOutcome("R9", 0);
    tick();
    reqValid = 0;

    summary();
  end

endmodule